// File: doc/BRIEF.md
# Bit-Vector Coherence Directory Controller

This block keeps the coherence state of a small shared memory that several private caches use. It keeps one entry for each tracked memory block. An entry holds one presence bit for each cache and an owner flag. The owner flag marks a block that one cache holds as its only copy, which that cache may modify without telling anyone. Caches send read or write-exclusive requests on a valid/ready request channel. The directory then sends invalidations or a downgrade to the caches that must give up rights, counts their acknowledgements, and issues a one-cycle grant on the response channel. The data itself lives outside the block.

Only one transaction is open at a time. This makes the directory the single point of ordering for every block. While a transaction is open, any new request waits on a low ready signal. An invalidation is a one-cycle pulse on a per-cache vector. A flag travelling with the pulse tells the target whether to drop its copy (0) or only downgrade it and keep it as a sharer (1). Each targeted cache answers with exactly one acknowledgement pulse on its bit of the acknowledge vector. Several caches may answer in the same cycle.

Top module: `coh_directory`

## Requirements
- R1: After reset, the request channel is ready, no invalidation or response is driven, and every block starts with no sharers and no owner.
- R2: A read of a block that has no owner, or whose owner is the requester, sends no invalidation. The read is granted in the first cycle after the request is accepted.
- R3: A write by a cache that does not own the block sends one invalidation pulse, with the downgrade flag at 0. The pulse goes to every cache whose presence bit is set, other than the requester.
- R4: The acknowledgement count is loaded with the number of caches targeted. Each cycle it drops by the number of acknowledge bits that are set, and the grant is issued only once it reaches zero. Acknowledgements may come all together or one per cycle.
- R5: A read of a block owned by another cache sends a single downgrade pulse, with the flag at 1, to the owner only. After that grant the owner flag is clear and both the owner and the reader are sharers.
- R6: After a write grant, the writer is the block's only sharer and its owner. A further write by that owner is granted with no invalidation, in the first cycle after acceptance.
- R7: Ready drops in the cycle after a request is accepted. It stays low until the grant has been issued, and it is high again in the cycle after the grant.
- R8: The grant carries the requester's cache index and block index. Its exclusive flag is 1 for a write and 0 for a read.
- R9: A write by a cache that is already a sharer never sends an invalidation to that cache.
- R10: The entries of different blocks are independent. A request to one block neither sees nor changes the sharers or owner of another block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The directory can accept a request |
| reqCache | input | $clog2(NUM_CACHES) | Index of the requesting cache |
| reqBlock | input | $clog2(NUM_BLOCKS) | Index of the requested block |
| reqWrite | input | 1 | 1 = write-exclusive, 0 = read |
| invValid | output | NUM_CACHES | One-cycle invalidation pulse, one bit per target cache |
| invDowngrade | output | 1 | With invValid: 1 = downgrade to sharer, 0 = drop the copy |
| ackValid | input | NUM_CACHES | Acknowledgement pulses, one bit per cache |
| respValid | output | 1 | One-cycle grant |
| respCache | output | $clog2(NUM_CACHES) | Cache receiving the grant |
| respBlock | output | $clog2(NUM_BLOCKS) | Block the grant is for |
| respExcl | output | 1 | 1 = exclusive permission, 0 = shared copy |

## Verification
The checker assumes two things about acknowledgements. A cache acknowledges only after an invalidation or downgrade has reached it, and it acknowledges each one exactly once. On that basis the checker keeps a count of outstanding acknowledgements and requires the count to be zero whenever a grant appears. The bench stays inside this assumption: it replies only to the bits it actually saw in an invalidation pulse, either all in the next cycle or one bit per cycle. It also presents a new request only after the previous grant, and it holds the request until ready is seen high.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INV,
    ST_WAIT,
    ST_RESP
  } dirState_e;

  typedef struct packed {
    logic latchReq;  // capture request and its lookup
    logic countAck;  // consume acknowledgements
    logic showInv;   // drive the invalidation pulse
    logic commit;    // write the new entry back
  } dirStrobe_t;

endpackage

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       noTargets,
  input  logic       ackDone,
  output logic       reqReady,
  output logic       respValid,
  output dirStrobe_t strobe
);

  dirState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    respValid = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext = noTargets ? ST_RESP : ST_INV;
        end
      end
      ST_INV: begin
        strobe.showInv  = 1'b1;
        strobe.countAck = 1'b1;
        stateNext = ackDone ? ST_RESP : ST_WAIT;
      end
      ST_WAIT: begin
        strobe.countAck = 1'b1;
        if (ackDone) stateNext = ST_RESP;
      end
      ST_RESP: begin
        respValid     = 1'b1;
        strobe.commit = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 8,
  localparam int CIDX_W = $clog2(NUM_CACHES),
  localparam int BIDX_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W  = $clog2(NUM_CACHES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dirStrobe_t            strobe,
  input  logic [CIDX_W-1:0]     reqCache,
  input  logic [BIDX_W-1:0]     reqBlock,
  input  logic                  reqWrite,
  input  logic [NUM_CACHES-1:0] ackValid,
  output logic                  noTargets,
  output logic                  ackDone,
  output logic [NUM_CACHES-1:0] invValid,
  output logic                  invDowngrade,
  output logic [CIDX_W-1:0]     respCache,
  output logic [BIDX_W-1:0]     respBlock,
  output logic                  respExcl
);

  localparam logic [NUM_CACHES-1:0] ONE_HOT0 = NUM_CACHES'(1);

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_CACHES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_CACHES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  // directory entries
  logic [NUM_CACHES-1:0] presence [NUM_BLOCKS];
  logic                  owned    [NUM_BLOCKS];

  // latched transaction
  logic [CIDX_W-1:0]     latCache;
  logic [BIDX_W-1:0]     latBlock;
  logic                  latWrite;
  logic [NUM_CACHES-1:0] targets;
  logic                  latDown;
  logic [CNT_W-1:0]      ackLeft;

  // lookup for an incoming request
  logic [NUM_CACHES-1:0] lookPres, reqBit, nextTargets;
  logic                  lookOwned, reqIsOwner, nextDown;

  always_comb begin
    lookPres   = presence[reqBlock];
    lookOwned  = owned[reqBlock];
    reqBit     = ONE_HOT0 << reqCache;
    reqIsOwner = lookOwned && lookPres[reqCache];
    if (reqWrite) begin
      nextTargets = reqIsOwner ? '0 : (lookPres & ~reqBit);
      nextDown    = 1'b0;
    end else begin
      nextTargets = (lookOwned && !reqIsOwner) ? lookPres : '0;
      nextDown    = 1'b1;
    end
  end

  assign noTargets = (nextTargets == '0);

  logic [CNT_W-1:0] ackCount;
  assign ackCount = popCount(ackValid);
  assign ackDone  = (ackCount >= ackLeft);

  // new entry value at commit
  logic [NUM_CACHES-1:0] comPres, latBit, newPres;
  logic                  comOwned, newOwned;

  always_comb begin
    comPres  = presence[latBlock];
    comOwned = owned[latBlock];
    latBit   = ONE_HOT0 << latCache;
    if (latWrite) begin
      newPres  = latBit;
      newOwned = 1'b1;
    end else if (comOwned && comPres[latCache]) begin
      newPres  = comPres;
      newOwned = 1'b1;
    end else begin
      newPres  = comPres | latBit;
      newOwned = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        presence[b] <= '0;
        owned[b]    <= 1'b0;
      end
    end else if (strobe.commit) begin
      presence[latBlock] <= newPres;
      owned[latBlock]    <= newOwned;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latCache <= '0;
      latBlock <= '0;
      latWrite <= 1'b0;
      targets  <= '0;
      latDown  <= 1'b0;
      ackLeft  <= '0;
    end else if (strobe.latchReq) begin
      latCache <= reqCache;
      latBlock <= reqBlock;
      latWrite <= reqWrite;
      targets  <= nextTargets;
      latDown  <= nextDown;
      ackLeft  <= popCount(nextTargets);
    end else if (strobe.countAck) begin
      ackLeft <= ackDone ? '0 : (ackLeft - ackCount);
    end
  end

  assign invValid     = strobe.showInv ? targets : '0;
  assign invDowngrade = strobe.showInv & latDown;
  assign respCache    = latCache;
  assign respBlock    = latBlock;
  assign respExcl     = latWrite;

endmodule

// File: rtl/coh_directory.sv
module coh_directory
  import dir_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 8,
  localparam int CIDX_W = $clog2(NUM_CACHES),
  localparam int BIDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [CIDX_W-1:0]     reqCache,
  input  logic [BIDX_W-1:0]     reqBlock,
  input  logic                  reqWrite,
  output logic [NUM_CACHES-1:0] invValid,
  output logic                  invDowngrade,
  input  logic [NUM_CACHES-1:0] ackValid,
  output logic                  respValid,
  output logic [CIDX_W-1:0]     respCache,
  output logic [BIDX_W-1:0]     respBlock,
  output logic                  respExcl
);

  dirStrobe_t strobe;
  logic       noTargets, ackDone;

  dir_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .noTargets (noTargets),
    .ackDone   (ackDone),
    .reqReady  (reqReady),
    .respValid (respValid),
    .strobe    (strobe)
  );

  dir_datapath #(
    .NUM_CACHES (NUM_CACHES),
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqCache     (reqCache),
    .reqBlock     (reqBlock),
    .reqWrite     (reqWrite),
    .ackValid     (ackValid),
    .noTargets    (noTargets),
    .ackDone      (ackDone),
    .invValid     (invValid),
    .invDowngrade (invDowngrade),
    .respCache    (respCache),
    .respBlock    (respBlock),
    .respExcl     (respExcl)
  );

endmodule

// File: rtl/dir_checker.sv
module dir_checker #(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 8,
  localparam int CIDX_W = $clog2(NUM_CACHES),
  localparam int BIDX_W = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqReady,
  input logic [CIDX_W-1:0]     reqCache,
  input logic [BIDX_W-1:0]     reqBlock,
  input logic                  reqWrite,
  input logic [NUM_CACHES-1:0] invValid,
  input logic                  invDowngrade,
  input logic [NUM_CACHES-1:0] ackValid,
  input logic                  respValid,
  input logic [CIDX_W-1:0]     respCache,
  input logic [BIDX_W-1:0]     respBlock,
  input logic                  respExcl
);

  logic [CIDX_W-1:0] lastCache;
  logic [BIDX_W-1:0] lastBlock;
  logic              lastWrite;
  logic [7:0]        pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCache <= '0;
      lastBlock <= '0;
      lastWrite <= 1'b0;
      pending   <= '0;
    end else begin
      if (reqValid && reqReady) begin
        lastCache <= reqCache;
        lastBlock <= reqBlock;
        lastWrite <= reqWrite;
      end
      pending <= pending + 8'($countones(invValid)) - 8'($countones(ackValid));
    end
  end

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_ready_after_grant_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> reqReady);

  assert_grant_fields_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respCache == lastCache && respBlock == lastBlock && respExcl == lastWrite));

  assert_no_self_inv_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|invValid) |-> !invValid[lastCache]);

  assert_grant_after_acks_R4: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (pending == 8'd0));

  assert_single_downgrade_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((|invValid) && invDowngrade) |-> ($countones(invValid) == 1));

endmodule

bind coh_directory dir_checker #(
  .NUM_CACHES (NUM_CACHES),
  .NUM_BLOCKS (NUM_BLOCKS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqCache     (reqCache),
  .reqBlock     (reqBlock),
  .reqWrite     (reqWrite),
  .invValid     (invValid),
  .invDowngrade (invDowngrade),
  .ackValid     (ackValid),
  .respValid    (respValid),
  .respCache    (respCache),
  .respBlock    (respBlock),
  .respExcl     (respExcl)
);

// File: tb/tb_coh_directory.sv
module tb_coh_directory;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqCache = '0;
  logic [2:0]    reqBlock = '0;
  logic          reqWrite = 1'b0;
  logic [NC-1:0] invValid;
  logic          invDowngrade;
  logic [NC-1:0] ackValid = '0;
  logic          respValid;
  logic [1:0]    respCache;
  logic [2:0]    respBlock;
  logic          respExcl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_directory #(.NUM_CACHES(NC), .NUM_BLOCKS(NB)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCache(reqCache), .reqBlock(reqBlock), .reqWrite(reqWrite),
    .invValid(invValid), .invDowngrade(invDowngrade), .ackValid(ackValid),
    .respValid(respValid), .respCache(respCache), .respBlock(respBlock),
    .respExcl(respExcl)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One transaction; ackOneByOne selects per-cycle acknowledgements.
  task automatic transact(input string tag, input int c, input int b, input bit wr,
                          input logic [NC-1:0] expInv, input bit expDown,
                          input bit ackOneByOne, input int expLatency);
    logic [NC-1:0] seenInv = '0;
    logic [NC-1:0] remain = '0;
    bit sawDown = 1'b0;
    bit early = 1'b0;
    bit busyOk = 1'b1;
    int cyc = 0;
    bit got = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqCache = 2'(c); reqBlock = 3'(b); reqWrite = wr;
    while (!reqReady) @(negedge clk);
    while (!got && cyc < 50) begin
      @(negedge clk);
      cyc++;
      reqValid = 1'b0;
      ackValid = '0;
      if (|invValid) begin
        seenInv = seenInv | invValid;
        remain  = remain | invValid;
        sawDown = invDowngrade;
      end
      if (respValid) begin
        got = 1'b1;
        if (remain != '0) early = 1'b1;
        check({tag, " R8 cache"}, respCache == 2'(c), respCache, c);
        check({tag, " R8 block"}, respBlock == 3'(b), respBlock, b);
        check({tag, " R8 excl"}, respExcl == wr, respExcl, wr);
      end else begin
        if (reqReady) busyOk = 1'b0;
        if (remain != '0) begin
          if (ackOneByOne) ackValid = remain & (~remain + 1'b1);
          else             ackValid = remain;
          remain = remain & ~ackValid;
        end
      end
    end
    ackValid = '0;
    check({tag, " grant seen"}, got, got, 1);
    check({tag, " R3 inv targets"}, seenInv == expInv, seenInv, expInv);
    if (expInv != '0)
      check({tag, " R5 downgrade flag"}, sawDown == expDown, sawDown, expDown);
    check({tag, " R4 no grant before acks"}, !early, early, 0);
    check({tag, " R7 ready low while busy"}, busyOk, busyOk, 1);
    if (expLatency > 0)
      check({tag, " R2 latency"}, cyc == expLatency, cyc, expLatency);
    @(negedge clk);
    check({tag, " R7 ready after grant"}, reqReady == 1'b1, reqReady, 1);
  endtask

  task automatic test_reset();
    check("R1 ready at reset", reqReady == 1'b1, reqReady, 1);
    check("R1 no inv at reset", invValid == '0, invValid, 0);
    check("R1 no grant at reset", respValid == 1'b0, respValid, 0);
  endtask

  task automatic test_shared_reads();
    transact("R2 read c0", 0, 1, 0, 4'b0000, 0, 0, 1);
    transact("R2 read c2", 2, 1, 0, 4'b0000, 0, 0, 1);
  endtask

  task automatic test_write_sharers();
    // R3 R4 R9: sharers c0 and c2, c1 writes, acks one per cycle
    transact("R3 write c1", 1, 1, 1, 4'b0101, 0, 1, 0);
  endtask

  task automatic test_downgrade();
    // R5: c3 reads block owned by c1
    transact("R5 read c3", 3, 1, 0, 4'b0010, 1, 0, 0);
    // both c1 and c3 must now be sharers, no owner
    transact("R5 write c0", 0, 1, 1, 4'b1010, 0, 0, 0);
  endtask

  task automatic test_owner_write();
    transact("R6 rewrite c0", 0, 1, 1, 4'b0000, 0, 0, 1);
    transact("R2 owner read c0", 0, 1, 0, 4'b0000, 0, 0, 1);
    transact("R6 still owner c0", 0, 1, 1, 4'b0000, 0, 0, 1);
  endtask

  task automatic test_sharer_write();
    transact("R9 read c3 b2", 3, 2, 0, 4'b0000, 0, 0, 1);
    transact("R9 read c1 b2", 1, 2, 0, 4'b0000, 0, 0, 1);
    transact("R9 write c1 b2", 1, 2, 1, 4'b1000, 0, 1, 0);
  endtask

  task automatic test_independent();
    transact("R10 read c2 b5", 2, 5, 0, 4'b0000, 0, 0, 1);
    transact("R10 write c3 b7", 3, 7, 1, 4'b0000, 0, 0, 1);
    // block 1 still owned by c0 only
    transact("R10 write c2 b1", 2, 1, 1, 4'b0001, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_shared_reads();
    test_write_sharers();
    test_downgrade();
    test_owner_write();
    test_sharer_write();
    test_independent();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule